// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt

This block is the timing and control core of a small 16-bit accumulator machine. A 4-bit step counter is decoded into sixteen one-hot timing lines. While no interrupt is pending, the block fetches the instruction word at the program counter and decodes its 3-bit opcode into eight one-hot lines. It loads the 12-bit address field and the indirect bit, and it resolves one level of indirection before execution starts. It then raises one of three phase indicators, and the execute units do the work. When an execute unit has finished, it pulses a clear strobe that returns the counter to the first step.

The block can also take an interrupt. An interrupt is armed when interrupts are enabled, an I/O flag is raised, and the sequencer is past the fetch steps. Once armed, the next pass through the first three steps becomes an interrupt cycle instead of a fetch. That cycle stores the program counter at word 0, sets the program counter to 1, and disables further interrupts.

Memory is external. It is word addressed and takes a synchronous write with a combinational read. The block drives the address from its AR register and makes at most one access per step. A halt input freezes the block until the next reset.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the step counter is 0 (`t` = 16'h0001), `r_flag` = 0, `ien` = 0 and `pc` = 0.
- R2: In a fetch pass (`r_flag` = 0), step T0 copies `pc` into `ar`. Step T1 loads `ir` from `mem_rdata` (read at address `ar`) and increments `pc`.
- R3: At fetch step T2, `ar` takes `ir[11:0]` and `i_flag` takes `ir[15]`. The output `d` is the one-hot decode of `ir[14:12]`, with bit n high for opcode n.
- R4: At T3, when `d[7]` = 0 and `i_flag` = 1, `ar` is replaced by bits [11:0] of the word read at `ar`. When `i_flag` = 0, `ar` is left unchanged.
- R5: The phase indicators work as follows:
  - `exec_mr` is high from T4 onward while `d[7]` = 0.
  - `exec_rr` is high at T3 when `d[7]` = 1 and `i_flag` = 0.
  - `exec_io` is high at T3 when `d[7]` = 1 and `i_flag` = 1.
- R6: Interrupt step T0 (`r_flag` = 1) clears `ar` and copies `pc` into `tr`.
- R7: Interrupt step T1 writes `tr` to memory word 0 (`mem_we` = 1, `mem_addr` = 0) and clears `pc`.
- R8: Interrupt step T2 sets `pc` to 1, clears `ien` and `r_flag`, and returns the counter to T0.
- R9: `r_flag` is set at a clock edge when `ien` = 1, `fgi` or `fgo` is 1, and the current step is not T0, T1 or T2. It is never set during the fetch steps.
- R10: Exactly one line of `t` is high. The counter advances by one each clock and wraps from T15 to T0. A high `sc_clr` sends it to T0 at the next edge.
- R11: A high `halt` blocks that clock edge and every later one until reset. During that time no register, counter or flag changes.
- R12: `ien_set` sets `ien` and `ien_clr` clears it. The interrupt cycle's clear takes priority over both.
- R13: `mem_we` is high only at interrupt step T1, so each interrupt writes memory exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low start/reset |
| halt | input | 1 | Stops the sequencer until reset |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| sc_clr | input | 1 | Clear-counter strobe from the execute units |
| ien_set | input | 1 | Enables interrupts |
| ien_clr | input | 1 | Disables interrupts |
| mem_rdata | input | 16 | Combinational read data at `mem_addr` |
| mem_addr | output | 12 | Memory word address (AR) |
| mem_wdata | output | 16 | Write data (TR) |
| mem_we | output | 1 | Write enable |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| tr | output | 16 | Temporary register |
| i_flag | output | 1 | Indirect bit |
| r_flag | output | 1 | Interrupt cycle pending/active |
| ien | output | 1 | Interrupt enable |
| t | output | 16 | One-hot timing steps T0..T15 |
| d | output | 8 | One-hot opcode lines D0..D7 |
| exec_mr | output | 1 | Memory-reference execute phase |
| exec_rr | output | 1 | Register-reference execute phase |
| exec_io | output | 1 | I/O execute phase |

## Verification
The bench runs all sixteen combinations of opcode and indirect bit through fetch and decode. A design that indirected on opcode 7, or skipped indirection on the others, would leave a wrong address in `ar` at T4. It also raises the wrong phase indicator.

An interrupt is armed while an I/O flag is already high during fetch. This catches a design that diverts too early and corrupts the instruction being fetched. The interrupt cycle is then checked step by step. A design that saved the already-cleared PC, or wrote to a non-zero address, would store the wrong word at location 0.

The counter is run to T15 and past it to show the wrap. Halt is raised in the middle of fetch to confirm that nothing moves afterwards.

// File: rtl/instr_sequencer.sv
module instr_sequencer #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int SCW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt,
  input  logic                 fgi,
  input  logic                 fgo,
  input  logic                 sc_clr,
  input  logic                 ien_set,
  input  logic                 ien_clr,
  input  logic [DW-1:0]        mem_rdata,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_we,
  output logic [AW-1:0]        pc,
  output logic [AW-1:0]        ar,
  output logic [DW-1:0]        ir,
  output logic [DW-1:0]        tr,
  output logic                 i_flag,
  output logic                 r_flag,
  output logic                 ien,
  output logic [(1<<SCW)-1:0] t,
  output logic [7:0]           d,
  output logic                 exec_mr,
  output logic                 exec_rr,
  output logic                 exec_io
);
  localparam int NT = 1 << SCW;

  logic [SCW-1:0] sc;
  logic           halted;
  logic           run;
  logic           arm;

  assign run       = !(halt || halted);
  assign t         = NT'(1) << sc;
  assign d         = 8'(1) << ir[DW-2 -: 3];
  assign mem_addr  = ar;
  assign mem_wdata = tr;
  assign mem_we    = run && r_flag && t[1];
  assign exec_mr   = !d[7] && (sc >= SCW'(4));
  assign exec_rr   = d[7] && !i_flag && t[3];
  assign exec_io   = d[7] && i_flag && t[3];
  assign arm       = ien && (fgi || fgo) && !(t[0] || t[1] || t[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
    end else if (halt) begin
      halted <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc     <= '0;
      pc     <= '0;
      ar     <= '0;
      ir     <= '0;
      tr     <= '0;
      i_flag <= 1'b0;
      r_flag <= 1'b0;
      ien    <= 1'b0;
    end else if (run) begin
      if (sc_clr || (r_flag && t[2])) sc <= '0;
      else                            sc <= sc + SCW'(1);

      if (!r_flag) begin
        if (t[0]) ar <= pc;
        if (t[1]) begin
          ir <= mem_rdata;
          pc <= pc + AW'(1);
        end
        if (t[2]) begin
          ar     <= ir[AW-1:0];
          i_flag <= ir[DW-1];
        end
        if (t[3] && !d[7] && i_flag) ar <= mem_rdata[AW-1:0];
      end else begin
        if (t[0]) begin
          ar <= '0;
          tr <= DW'(pc);
        end
        if (t[1]) pc <= '0;
        if (t[2]) begin
          pc     <= pc + AW'(1);
          r_flag <= 1'b0;
        end
      end

      if (arm) r_flag <= 1'b1;

      if (r_flag && t[2]) ien <= 1'b0;
      else if (ien_clr)   ien <= 1'b0;
      else if (ien_set)   ien <= 1'b1;
    end
  end
endmodule

// File: rtl/instr_sequencer_chk.sv
module instr_sequencer_chk #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int SCW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 halted,
  input logic                 fgi,
  input logic                 fgo,
  input logic                 sc_clr,
  input logic [AW-1:0]        mem_addr,
  input logic                 mem_we,
  input logic [AW-1:0]        pc,
  input logic [AW-1:0]        ar,
  input logic [DW-1:0]        ir,
  input logic [DW-1:0]        tr,
  input logic                 i_flag,
  input logic                 r_flag,
  input logic                 ien,
  input logic [(1<<SCW)-1:0] t
);
  AST_FETCH_AR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !r_flag && t[0]) |=> (ar == $past(pc))); // R2
  AST_DECODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !r_flag && t[2]) |=> (ar == $past(ir[AW-1:0]) && i_flag == $past(ir[DW-1]))); // R3
  AST_INT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && r_flag && t[0]) |=> (ar == '0 && tr == DW'($past(pc)))); // R6
  AST_INT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && r_flag && t[1]) |-> (mem_we && mem_addr == '0)); // R7
  AST_INT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run && r_flag && t[2]) |=> (!r_flag && !ien && t[0] && pc == AW'(1))); // R8
  AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ien && (fgi || fgo) && !(t[0] || t[1] || t[2])) |=> r_flag); // R9
  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t) == 1); // R10
  AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc_clr) |=> t[0]); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(t) && $stable(pc) && $stable(ar) && $stable(ir))); // R11
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (r_flag && t[1])); // R13
endmodule

bind instr_sequencer instr_sequencer_chk #(.AW(AW), .DW(DW), .SCW(SCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .halted(halted), .fgi(fgi), .fgo(fgo),
  .sc_clr(sc_clr), .mem_addr(mem_addr), .mem_we(mem_we), .pc(pc), .ar(ar),
  .ir(ir), .tr(tr), .i_flag(i_flag), .r_flag(r_flag), .ien(ien), .t(t)
);

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0, fgi = 1'b0, fgo = 1'b0, sc_clr = 1'b0;
  logic        ien_set = 1'b0, ien_clr = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr, pc, ar;
  logic [15:0] mem_wdata, ir, tr;
  logic        mem_we, i_flag, r_flag, ien, exec_mr, exec_rr, exec_io;
  logic [15:0] t;
  logic [7:0]  d;

  logic [15:0] mem [4096];
  int          n_chk = 0, n_bad = 0, n_wr = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    n_wr++;
  end

  instr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .fgi(fgi), .fgo(fgo), .sc_clr(sc_clr),
    .ien_set(ien_set), .ien_clr(ien_clr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .pc(pc), .ar(ar), .ir(ir), .tr(tr), .i_flag(i_flag), .r_flag(r_flag),
    .ien(ien), .t(t), .d(d), .exec_mr(exec_mr), .exec_rr(exec_rr), .exec_io(exec_io)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_instr();
    logic [11:0] p0, a, expa;
    logic [15:0] w;
    logic [2:0]  op;
    logic        ib;
    p0 = pc; w = mem[p0]; op = w[14:12]; ib = w[15]; a = w[11:0];
    step();
    chk(ar == p0, "R2 ar at T1", 32'(ar), 32'(p0));
    chk(t == 16'h0002, "R10 step T1", 32'(t), 32'h2);
    step();
    chk(ir == w, "R2 ir loaded", 32'(ir), 32'(w));
    chk(pc == p0 + 12'd1, "R2 pc incremented", 32'(pc), 32'(p0 + 12'd1));
    step();
    chk(ar == a, "R3 address field", 32'(ar), 32'(a));
    chk(i_flag == ib, "R3 indirect bit", 32'(i_flag), 32'(ib));
    chk(d == (8'(1) << op), "R3 opcode decode", 32'(d), 32'(8'(1) << op));
    chk(r_flag == 1'b0, "R9 no arm during fetch", 32'(r_flag), 32'h0);
    if (op == 3'd7) begin
      chk(exec_rr == !ib && exec_io == ib && !exec_mr, "R5 T3 phase",
          {29'd0, exec_mr, exec_rr, exec_io}, {29'd0, 1'b0, !ib, ib});
      sc_clr = 1'b1; step(); sc_clr = 1'b0;
      chk(ar == a, "R4 no indirect on D7", 32'(ar), 32'(a));
    end else begin
      chk(!exec_mr && !exec_rr && !exec_io, "R5 none at T3",
          {29'd0, exec_mr, exec_rr, exec_io}, 32'h0);
      step();
      expa = ib ? mem[a][11:0] : a;
      chk(ar == expa, "R4 effective address", 32'(ar), 32'(expa));
      chk(exec_mr && !exec_rr && !exec_io, "R5 T4 phase",
          {29'd0, exec_mr, exec_rr, exec_io}, 32'h4);
      sc_clr = 1'b1; step(); sc_clr = 1'b0;
    end
    chk(t == 16'h0001, "R10 clear to T0", 32'(t), 32'h1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [11:0] ps, a;
    logic [15:0] st, sp, sa;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    for (int k = 0; k < 16; k++) begin
      a = 12'(200 + k * 13);
      mem[k] = {k[3], k[2:0], a};
      mem[a] = 16'(16'h3000 + k * 97);
    end
    mem[16] = {1'b0, 3'd2, 12'd300};
    mem[17] = {1'b0, 3'd1, 12'd301};

    ien_set = 1'b1;
    step(); step();
    chk(t == 16'h0001 && !r_flag && !ien && pc == 0, "R1 reset state",
        {t, 4'd0, pc}, 32'h0001_0000);
    ien_set = 1'b0;
    rst_n = 1'b1;
    step();
    chk(t == 16'h0002 && pc == 0 && !ien && !r_flag, "R1 after release",
        {t, 4'd0, pc}, 32'h0002_0000);
    rst_n = 1'b0; step(); rst_n = 1'b1;

    for (int k = 0; k < 16; k++) do_instr();

    ien_set = 1'b1;
    do_instr();
    ien_set = 1'b0;
    chk(ien == 1'b1, "R12 enable set", 32'(ien), 32'h1);
    chk(r_flag == 1'b0, "R9 no flag no arm", 32'(r_flag), 32'h0);

    fgo = 1'b1;
    do_instr();
    fgo = 1'b0;
    chk(r_flag == 1'b1, "R9 armed by fgo", 32'(r_flag), 32'h1);
    ps = pc;
    step();
    chk(ar == 0 && tr == 16'(ps), "R6 save step", {4'd0, ar, tr}, {16'd0, 16'(ps)});
    step();
    chk(pc == 0, "R7 pc cleared", 32'(pc), 32'h0);
    chk(mem[0] == 16'(ps), "R7 return saved at 0", 32'(mem[0]), 32'(ps));
    step();
    chk(pc == 12'd1 && !r_flag && !ien && t == 16'h0001, "R8 exit step",
        {t, 1'b0, r_flag, ien, 1'b0, pc}, {16'h0001, 4'd0, 12'd1});
    chk(n_wr == 1, "R13 single write", 32'(n_wr), 32'h1);

    ien_set = 1'b1; do_instr(); ien_set = 1'b0;
    ien_clr = 1'b1; fgi = 1'b1; do_instr(); ien_clr = 1'b0;
    chk(ien == 1'b0, "R12 enable cleared", 32'(ien), 32'h0);
    chk(r_flag == 1'b0, "R9 disabled no arm", 32'(r_flag), 32'h0);
    fgi = 1'b0;

    step();
    halt = 1'b1;
    st = t; sp = 16'(pc); sa = 16'(ar);
    step();
    halt = 1'b0;
    for (int i = 0; i < 5; i++) begin
      ien_set = 1'b1; sc_clr = 1'b1;
      step();
      chk(t == st && 16'(pc) == sp && 16'(ar) == sa && !ien, "R11 frozen",
          {t, pc, 4'd0}, {st, sp[11:0], 4'd0});
    end
    ien_set = 1'b0; sc_clr = 1'b0;

    rst_n = 1'b0; step(); rst_n = 1'b1;
    for (int n = 1; n <= 18; n++) begin
      step();
      chk(t == (16'(1) << (n % 16)), "R10 count and wrap", 32'(t), 32'(16'(1) << (n % 16)));
    end
    chk(n_wr == 1, "R13 no extra write", 32'(n_wr), 32'h1);
    summary();
  end
endmodule